// File: doc/BRIEF.md
# Serial/Parallel Shift Register with Sign Replication

This block is an eight-stage register that updates on the rising clock edge. It has four clocked behaviours. It can keep its contents. It can move every bit one place toward the low end while taking a new top bit from one of two serial inputs. It can make that same move while the top bit keeps its own value, which copies the sign of a two's-complement word downward. It can also capture a whole word at once.

The word is captured from, and presented on, a single shared parallel port. For synthesis that port is split into an input vector, an output vector and an output-enable flag. The flag drops whenever the block is set for a parallel capture, so that the pad can act as an input. It also drops whenever the separate active-low drive control is high. The lowest stage is also brought out on its own serial output, which is always driven. An active-low asynchronous reset clears every stage and overrides all clocked behaviour.

The block moves no stream of data and has no handshake. Every pin is a plain control or data level, and every behaviour takes effect at the next clock edge.

Top module: `sxshift_reg`

## Requirements
- R1: While `arst_n` is low, all stages read 0 on `pio_out` and `tail_bit` at once, without waiting for a clock edge, and they stay 0 across clock edges whatever the other controls are.
- R2: At a rising edge with `run_n` high, the contents do not change, whatever the other controls and data inputs are.
- R3: At a rising edge with `run_n` low and `shift_sel` high, every stage i below the top takes the previous value of stage i+1.
- R4: In the R3 case with `replicate_n` high, the top stage (bit 7) takes `sdata_a` when `src_pick` is 0, and `sdata_b` when `src_pick` is 1.
- R5: In the R3 case with `replicate_n` low, the top stage (bit 7) keeps its previous value. Over repeated edges this fills the word with its sign bit, for both negative and positive values.
- R6: At a rising edge with `run_n` low and `shift_sel` low, all 8 stages load from `pio_in`.
- R7: `pio_oe` is 1 exactly when `drive_n` is 0 and `shift_sel` is 1. Neither reset nor `run_n` affects it.
- R8: With `drive_n` high, shifting and parallel capture still update the contents as in R3 to R6.
- R9: `pio_out` always equals the register contents, and `tail_bit` always equals stage 0. After a shift, `tail_bit` equals the previous stage 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| arst_n | input | 1 | Asynchronous clear, active low |
| run_n | input | 1 | Active-low update enable; high means hold |
| shift_sel | input | 1 | 1 = shift toward bit 0, 0 = parallel capture |
| replicate_n | input | 1 | Active-low sign replication during shift |
| src_pick | input | 1 | Serial source select: 0 = sdata_a, 1 = sdata_b |
| sdata_a | input | 1 | Serial data source 0 |
| sdata_b | input | 1 | Serial data source 1 |
| drive_n | input | 1 | Active-low parallel port drive control |
| pio_in | input | 8 | Parallel capture data from the shared port |
| pio_out | output | 8 | Register contents to the shared port |
| pio_oe | output | 1 | Shared port drive enable |
| tail_bit | output | 1 | Stage 0, always driven |

## Verification
Each clocked result (hold, shift, serial entry, sign replication, capture) appears on `pio_out` and `tail_bit` one edge after the controls that select it. The bench therefore sets the controls after a falling edge and reads the outputs a quarter period after the next rising edge. `pio_oe` is combinational from `drive_n` and `shift_sel`, so the bench reads it in the same window, against the controls still applied. The reset check pulls `arst_n` low in the middle of a cycle and reads the cleared outputs before any further edge arrives. It then lets one edge pass with a capture requested and confirms that the clear still holds.

// File: rtl/sxshift_pkg.sv
package sxshift_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_SHIFT = 2'd1,
    MODE_SIGNX = 2'd2,
    MODE_LOAD  = 2'd3
  } sx_mode_e;

endpackage

// File: rtl/sx_mode_dec.sv
module sx_mode_dec
  import sxshift_pkg::*;
(
  input  logic     run_n,
  input  logic     shift_sel,
  input  logic     replicate_n,
  output sx_mode_e mode
);

  // Priority: hold, then capture, then shift variants.
  always_comb begin
    if (run_n)             mode = MODE_HOLD;
    else if (!shift_sel)   mode = MODE_LOAD;
    else if (!replicate_n) mode = MODE_SIGNX;
    else                   mode = MODE_SHIFT;
  end

endmodule

// File: rtl/sx_ser_mux.sv
module sx_ser_mux #(
  parameter int NSRC = 2,
  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] src,
  input  logic [SELW-1:0] sel,
  output logic            bit_o
);

  always_comb begin
    bit_o = src[0];
    for (int k = 0; k < NSRC; k++) begin
      if (sel == SELW'(k)) bit_o = src[k];
    end
  end

endmodule

// File: rtl/sx_next.sv
module sx_next
  import sxshift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  sx_mode_e           mode,
  input  logic [WIDTH-1:0]   cur,
  input  logic [WIDTH-1:0]   par_in,
  input  logic               ser_in,
  output logic [WIDTH-1:0]   nxt
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == WIDTH - 1) begin : g_top
      always_comb begin
        unique case (mode)
          MODE_LOAD:  nxt[i] = par_in[i];
          MODE_SHIFT: nxt[i] = ser_in;
          MODE_SIGNX: nxt[i] = cur[i];
          default:    nxt[i] = cur[i];
        endcase
      end
    end else begin : g_body
      always_comb begin
        unique case (mode)
          MODE_LOAD:  nxt[i] = par_in[i];
          MODE_SHIFT,
          MODE_SIGNX: nxt[i] = cur[i+1];
          default:    nxt[i] = cur[i];
        endcase
      end
    end
  end

endmodule

// File: rtl/sxshift_reg.sv
module sxshift_reg
  import sxshift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             run_n,
  input  logic             shift_sel,
  input  logic             replicate_n,
  input  logic             src_pick,
  input  logic             sdata_a,
  input  logic             sdata_b,
  input  logic             drive_n,
  input  logic [WIDTH-1:0] pio_in,
  output logic [WIDTH-1:0] pio_out,
  output logic             pio_oe,
  output logic             tail_bit
);

  sx_mode_e         mode;
  logic             ser_bit;
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_d;

  sx_mode_dec u_dec (
    .run_n       (run_n),
    .shift_sel   (shift_sel),
    .replicate_n (replicate_n),
    .mode        (mode)
  );

  sx_ser_mux #(.NSRC(2)) u_mux (
    .src   ({sdata_b, sdata_a}),
    .sel   (src_pick),
    .bit_o (ser_bit)
  );

  sx_next #(.WIDTH(WIDTH)) u_next (
    .mode   (mode),
    .cur    (stage_q),
    .par_in (pio_in),
    .ser_in (ser_bit),
    .nxt    (stage_d)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  // Port drive drops during capture or when drive_n is high.
  assign pio_oe   = shift_sel & ~drive_n;
  assign pio_out  = stage_q;
  assign tail_bit = stage_q[0];

endmodule

// File: rtl/sxshift_reg_chk.sv
module sxshift_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             arst_n,
  input logic             run_n,
  input logic             shift_sel,
  input logic             replicate_n,
  input logic             src_pick,
  input logic             sdata_a,
  input logic             sdata_b,
  input logic             drive_n,
  input logic [WIDTH-1:0] pio_in,
  input logic [WIDTH-1:0] pio_out,
  input logic             pio_oe,
  input logic             tail_bit
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !arst_n |-> (pio_out == '0 && !tail_bit)); // R1

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!arst_n)
    run_n |=> $stable(pio_out)); // R2

  AST_SHIFT_BODY: assert property (@(posedge clk) disable iff (!arst_n)
    (!run_n && shift_sel) |=> pio_out[WIDTH-2:0] == $past(pio_out[WIDTH-1:1])); // R3

  AST_SERIAL_TOP: assert property (@(posedge clk) disable iff (!arst_n)
    (!run_n && shift_sel && replicate_n)
      |=> pio_out[WIDTH-1] == $past(src_pick ? sdata_b : sdata_a)); // R4

  AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (!arst_n)
    (!run_n && shift_sel && !replicate_n) |=> $stable(pio_out[WIDTH-1])); // R5

  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!arst_n)
    (!run_n && !shift_sel) |=> pio_out == $past(pio_in)); // R6

  AST_OE_CAPTURE_OFF: assert property (@(posedge clk)
    !shift_sel |-> !pio_oe); // R7

  AST_OE_DRIVE_OFF: assert property (@(posedge clk)
    drive_n |-> !pio_oe); // R7

  AST_LOAD_UNDRIVEN: assert property (@(posedge clk) disable iff (!arst_n)
    (drive_n && !run_n && !shift_sel) |=> pio_out == $past(pio_in)); // R8

  AST_TAIL_SHIFT: assert property (@(posedge clk) disable iff (!arst_n)
    (!run_n && shift_sel) |=> tail_bit == $past(pio_out[1])); // R9

endmodule

bind sxshift_reg sxshift_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .arst_n      (arst_n),
  .run_n       (run_n),
  .shift_sel   (shift_sel),
  .replicate_n (replicate_n),
  .src_pick    (src_pick),
  .sdata_a     (sdata_a),
  .sdata_b     (sdata_b),
  .drive_n     (drive_n),
  .pio_in      (pio_in),
  .pio_out     (pio_out),
  .pio_oe      (pio_oe),
  .tail_bit    (tail_bit)
);

// File: tb/sxshift_reg_bench.sv
module sxshift_reg_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  typedef struct packed {
    logic       run_n;
    logic       shift_sel;
    logic       replicate_n;
    logic       src_pick;
    logic       sdata_a;
    logic       sdata_b;
    logic       drive_n;
    logic [7:0] pin;
    logic [7:0] exp_q;
    logic       exp_oe;
  } vec_t;

  // Expected contents after the edge; reset leaves 00.
  localparam vec_t TBL [NVEC] = '{
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'hA5,8'hA5,1'b0}, // R6 capture
    '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,8'h00,8'hA5,1'b1}, // R2 hold
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,8'hFF,8'hA5,1'b0}, // R2 hold, capture ignored
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,8'h00,8'hD2,1'b1}, // R4 source a
    '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,8'h00,8'h69,1'b1}, // R4 source b = 0
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,8'h00,8'hB4,1'b1}, // R4 source b = 1
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'hDA,1'b1}, // R5 negative
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'hED,1'b1}, // R5
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,8'h00,8'hF6,1'b1}, // R5 serial ignored
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,8'h35,8'h35,1'b0}, // R8 capture undriven
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,8'h00,8'h1A,1'b0}, // R8 positive shift undriven
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,8'h0D,1'b1}, // R5 positive
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h06,1'b1}, // R5
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,8'h00,8'h03,1'b1}  // R3 R9 tail from bit 1
  };

  logic       clk = 1'b0;
  logic       arst_n = 1'b1;
  logic       run_n = 1'b1;
  logic       shift_sel = 1'b1;
  logic       replicate_n = 1'b1;
  logic       src_pick = 1'b0;
  logic       sdata_a = 1'b0;
  logic       sdata_b = 1'b0;
  logic       drive_n = 1'b1;
  logic [7:0] pio_in = 8'h00;
  logic [7:0] pio_out;
  logic       pio_oe;
  logic       tail_bit;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sxshift_reg u_sxshift_reg (
    .clk(clk), .arst_n(arst_n), .run_n(run_n), .shift_sel(shift_sel),
    .replicate_n(replicate_n), .src_pick(src_pick), .sdata_a(sdata_a),
    .sdata_b(sdata_b), .drive_n(drive_n), .pio_in(pio_in),
    .pio_out(pio_out), .pio_oe(pio_oe), .tail_bit(tail_bit)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    #1 arst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset out", pio_out, 8'h00);
    chk("R9 reset tail", {7'b0, tail_bit}, 8'h00);
    arst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      run_n = TBL[v].run_n; shift_sel = TBL[v].shift_sel;
      replicate_n = TBL[v].replicate_n; src_pick = TBL[v].src_pick;
      sdata_a = TBL[v].sdata_a; sdata_b = TBL[v].sdata_b;
      drive_n = TBL[v].drive_n; pio_in = TBL[v].pin;
      @(posedge clk);
      #(CLK_PERIOD/4);
      chk($sformatf("R3-6 row %0d contents", v), pio_out, TBL[v].exp_q);
      chk($sformatf("R7 row %0d oe", v), {7'b0, pio_oe}, {7'b0, TBL[v].exp_oe});
      chk($sformatf("R9 row %0d tail", v), {7'b0, tail_bit}, {7'b0, TBL[v].exp_q[0]});
    end

    // Directed: capture FF, then clear in mid-cycle.
    @(negedge clk);
    run_n = 1'b0; shift_sel = 1'b0; drive_n = 1'b0; pio_in = 8'hFF;
    @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R6 capture FF", pio_out, 8'hFF);
    arst_n = 1'b0;
    #1;
    chk("R1 async clear before edge", pio_out, 8'h00);
    chk("R1 async clear tail", {7'b0, tail_bit}, 8'h00);
    @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R1 clear overrides capture", pio_out, 8'h00);
    shift_sel = 1'b1; drive_n = 1'b0; run_n = 1'b1;
    #1;
    chk("R7 oe during reset", {7'b0, pio_oe}, 8'h01);
    drive_n = 1'b1;
    #1;
    chk("R7 drive_n off during reset", {7'b0, pio_oe}, 8'h00);
    @(negedge clk);
    arst_n = 1'b1;
    run_n = 1'b0; shift_sel = 1'b1; replicate_n = 1'b1;
    src_pick = 1'b1; sdata_a = 1'b0; sdata_b = 1'b1; drive_n = 1'b0;
    @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R4 entry after reset", pio_out, 8'h80);
    chk("R7 run_n low oe", {7'b0, pio_oe}, 8'h01);

    done = 1'b1;
    finish_run();
  end

endmodule